// File: doc/BRIEF.md
# Supply Mode Sequencer

This block is the digital mode supervisor of a flyback power-supply controller. It takes comparator flags on the supply rail, the regulation node and the fault inputs. From them it decides whether the power switch may be driven. It also paces the stepped soft-start ramp and picks which supply turn-off level the analog comparator uses.

The sequencer has four modes. In start-up it waits for the turn-on flag. Soft-start then runs for a fixed number of equal steps. During soft-start a charging source is on for a short window at the start, and the sink-current code counts down once per step. After soft-start the block stays in normal operation. It can fall into burst mode, which keeps the gate off and selects the raised turn-off level. It goes back to start-up whenever the supply drops to the selected turn-off level.

Two sticky protection latches block the gate on their own, whatever the mode. One catches overvoltage and overcurrent, the other catches mains undervoltage. Both are released once the supply falls below the release level.

Top module: `supply_mode_sequencer`

## Requirements
- R1: After reset the block is in start-up: `gate_en`, `src_en` and `off_sel_high` are 0 and `sink_code` is 0. It stays in start-up, with the gate off, for as long as `vcc_above_on` is 0.
- R2: The cycle after `vcc_above_on` is sampled high in start-up, soft-start begins. `src_en` is 1 for exactly the first `ARM_CYC` cycles of soft-start and 0 after that.
- R3: In soft-start cycle k (counted from 0), `sink_code` equals `STEPS-1 - floor(k / STEP_CYC)`. In every other mode `sink_code` is 0.
- R4: Soft-start lasts exactly `STEPS*STEP_CYC` cycles and is followed by normal mode. `gate_en` is 1 throughout both when no latch is set.
- R5: The burst request is ignored during the first `ARM_CYC` soft-start cycles. From cycle `ARM_CYC` of soft-start onward, and in normal mode, a sampled burst request enters burst mode in the next cycle. In burst mode `gate_en` is 0 and `off_sel_high` becomes 1 (1 selects the raised 14.5 V turn-off level, 0 the normal 9 V level).
- R6: Burst mode is held, with the gate off, after the burst request goes away. Only `vcc_below_off` ends it.
- R7: `vcc_below_off` in soft-start, normal or burst mode returns the block to start-up in the next cycle, with the soft-start timers cleared. `off_sel_high` keeps its value in start-up and is cleared on the next turn-on. A later soft-start starts again at code `STEPS-1` with `src_en` high.
- R8: `vcc_above_ovp` or `ocp_fault` sets a fault latch that forces `gate_en` to 0 from the next cycle and holds it there. The latch clears when `vcc_below_rel` is sampled high with no fault present; a fault in the same cycle wins.
- R9: `mains_low` sets a separate latch with the same gating and release behaviour as R8.
- R10: `gate_en` is 1 only in soft-start or normal mode with both latches clear. A latch set during start-up keeps the gate off through the following soft-start, even while `src_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_above_on | input | 1 | Supply is above the turn-on level |
| vcc_below_off | input | 1 | Supply is below the selected turn-off level |
| vcc_above_ovp | input | 1 | Supply is above the overvoltage level |
| vcc_below_rel | input | 1 | Supply is below the turn-on level minus the burst hysteresis |
| reg_below_burst | input | 1 | Regulation node is below the burst level |
| ocp_fault | input | 1 | Overcurrent comparator has tripped |
| mains_low | input | 1 | Start-up current, sampled in the off-time, is below the mains limit |
| gate_en | output | 1 | Permission to drive the power switch |
| src_en | output | 1 | Enable for the soft-start charging source |
| sink_code | output | SINK_W | Stepped sink-current code for the regulation node |
| off_sel_high | output | 1 | 1 selects the raised turn-off level |

## Verification
A corrupted step or sub-step count shows up on `sink_code` within one step period, as a code that comes too early, too late or out of order. A wrong mode shows up on `gate_en` or `off_sel_high` in the very next cycle. A latch that is stuck or released early shows up on `gate_en` as soon as the block sits in soft-start or normal mode. The bench sweeps every soft-start cycle of a small configuration against the arithmetic code formula. It also drives each burst, exit and latch edge case exactly at its boundary cycle.

// File: rtl/pms_pkg.sv
// Shared types for the supply mode sequencer.
package pms_pkg;
    typedef enum logic [1:0] {
        MODE_START = 2'd0,
        MODE_SOFT  = 2'd1,
        MODE_RUN   = 2'd2,
        MODE_BURST = 2'd3
    } pms_mode_t;
endpackage

// File: rtl/pms_softstart_timer.sv
// Soft-start timer: one sub-step counter and one step index.
// It produces the source window, the burst-arming flag, the end-of-ramp
// strobe and the descending sink code.
// Assumes ARM_CYC < STEP_CYC. Every counter clears whenever run is low.
module pms_softstart_timer #(
    parameter int ARM_CYC  = 12,
    parameter int STEP_CYC = 3000,
    parameter int STEPS    = 8,
    parameter int SINK_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              src_en,
    output logic              armed,
    output logic              done,
    output logic [SINK_W-1:0] sink_code
);
    localparam int              SUB_W    = $clog2(STEP_CYC + 1);
    localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(STEP_CYC - 1);
    localparam logic [SUB_W-1:0]  ARM_LAST = SUB_W'(ARM_CYC - 1);
    localparam logic [SINK_W-1:0] IDX_LAST = SINK_W'(STEPS - 1);

    logic [SUB_W-1:0]  sub_q;
    logic [SINK_W-1:0] idx_q;
    logic              arm_q;

    // Advance the sub-step and step counters; latch the arming point.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q <= '0;
            idx_q <= '0;
            arm_q <= 1'b0;
        end else begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                if (idx_q != IDX_LAST) idx_q <= idx_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
            if (idx_q == '0 && sub_q == ARM_LAST) arm_q <= 1'b1;
        end
    end

    // Decode the outputs from the counter state.
    always_comb begin
        src_en    = run && !arm_q;
        armed     = run && arm_q;
        done      = run && (idx_q == IDX_LAST) && (sub_q == SUB_LAST);
        sink_code = run ? (IDX_LAST - idx_q) : '0;
    end

    // R3: during a ramp the code never rises
    assert_code_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (sink_code <= $past(sink_code)));

    // R2: the source is only on while the first step is active
    assert_src_first_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_en |-> (sink_code == IDX_LAST));
endmodule

// File: rtl/pms_mode_fsm.sv
// Mode state machine: start-up, soft-start, normal run and burst.
// It also owns the turn-off level select, which is set on burst entry
// and cleared at the next turn-on. A supply drop beats a burst request.
module pms_mode_fsm
    import pms_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      above_on,
    input  logic      below_off,
    input  logic      burst_req,
    input  logic      armed,
    input  logic      ss_done,
    output pms_mode_t mode,
    output logic      off_sel_high
);
    pms_mode_t mode_d;

    // Next-mode selection.
    always_comb begin
        mode_d = mode;
        unique case (mode)
            MODE_START: if (above_on) mode_d = MODE_SOFT;
            MODE_SOFT: begin
                if (below_off)               mode_d = MODE_START;
                else if (armed && burst_req) mode_d = MODE_BURST;
                else if (ss_done)            mode_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (below_off)      mode_d = MODE_START;
                else if (burst_req) mode_d = MODE_BURST;
            end
            MODE_BURST: if (below_off) mode_d = MODE_START;
        endcase
    end

    // Mode register and turn-off level select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode         <= MODE_START;
            off_sel_high <= 1'b0;
        end else begin
            mode <= mode_d;
            if (mode == MODE_START && mode_d == MODE_SOFT)
                off_sel_high <= 1'b0;
            else if (mode != MODE_BURST && mode_d == MODE_BURST)
                off_sel_high <= 1'b1;
        end
    end

    // R5: the raised level is only selected on entering burst
    assert_sel_on_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_sel_high) |-> (mode == MODE_BURST));

    // R7: leaving start-up always goes to soft-start with the normal level
    assert_restart_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_START && mode != MODE_START) |-> (mode == MODE_SOFT && !off_sel_high));

    // R7: a supply drop in any active mode returns to start-up
    assert_drop_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(below_off) && $past(mode) != MODE_START) |-> (mode == MODE_START));
endmodule

// File: rtl/pms_fault_latch.sv
// Sticky protection latches: index 0 holds overvoltage/overcurrent,
// index 1 holds mains undervoltage. Each is released by the supply
// release flag only when its own set source is inactive.
module pms_fault_latch #(
    parameter int N_LATCH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovp,
    input  logic ocp,
    input  logic mains_low,
    input  logic release_ok,
    output logic inhibit
);
    logic [N_LATCH-1:0] set_vec;
    logic [N_LATCH-1:0] lat_q;

    // Gather the set sources.
    always_comb begin
        set_vec    = '0;
        set_vec[0] = ovp | ocp;
        set_vec[N_LATCH-1] = set_vec[N_LATCH-1] | mains_low;
    end

    for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
        // Set dominates release.
        always_ff @(posedge clk) begin
            if (!rst_n)          lat_q[i] <= 1'b0;
            else if (set_vec[i]) lat_q[i] <= 1'b1;
            else if (release_ok) lat_q[i] <= 1'b0;
        end
    end

    assign inhibit = |lat_q;

    // R8: a fault is held on the following cycle
    assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovp | ocp) |-> inhibit);

    // R9: mains undervoltage is held on the following cycle
    assert_mains_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mains_low) |-> inhibit);
endmodule

// File: rtl/supply_mode_sequencer.sv
// Top of the supply mode sequencer. It joins the mode machine, the
// soft-start timer and the protection latches, and gates the switch
// permission. All timings are counted in clock cycles.
module supply_mode_sequencer #(
    parameter int ARM_CYC  = 12,
    parameter int STEP_CYC = 3000,
    parameter int STEPS    = 8,
    localparam int SINK_W  = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_above_on,
    input  logic              vcc_below_off,
    input  logic              vcc_above_ovp,
    input  logic              vcc_below_rel,
    input  logic              reg_below_burst,
    input  logic              ocp_fault,
    input  logic              mains_low,
    output logic              gate_en,
    output logic              src_en,
    output logic [SINK_W-1:0] sink_code,
    output logic              off_sel_high
);
    import pms_pkg::*;

    pms_mode_t mode;
    logic      armed;
    logic      ss_done;
    logic      inhibit;
    logic      ss_run;

    assign ss_run = (mode == MODE_SOFT);

    pms_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_on    (vcc_above_on),
        .below_off   (vcc_below_off),
        .burst_req   (reg_below_burst),
        .armed       (armed),
        .ss_done     (ss_done),
        .mode        (mode),
        .off_sel_high(off_sel_high)
    );

    pms_softstart_timer #(
        .ARM_CYC (ARM_CYC),
        .STEP_CYC(STEP_CYC),
        .STEPS   (STEPS),
        .SINK_W  (SINK_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ss_run),
        .src_en   (src_en),
        .armed    (armed),
        .done     (ss_done),
        .sink_code(sink_code)
    );

    pms_fault_latch #(.N_LATCH(2)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovp       (vcc_above_ovp),
        .ocp       (ocp_fault),
        .mains_low (mains_low),
        .release_ok(vcc_below_rel),
        .inhibit   (inhibit)
    );

    // Switch permission: active modes only, no latch set.
    always_comb gate_en = (mode == MODE_SOFT || mode == MODE_RUN) && !inhibit;

    // R10: any protection input blocks the gate on the next cycle
    assert_gate_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vcc_above_ovp | ocp_fault | mains_low) |-> !gate_en);

    // R5: burst mode never drives the gate
    assert_burst_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST) |-> (!gate_en && off_sel_high));
endmodule

// File: tb/supply_mode_sequencer_tb.sv
// Bench: small configuration. Inputs are driven and outputs sampled
// on falling edges; expected values come from the requirement formulas.
module supply_mode_sequencer_tb;
    localparam int CLK_P = 10;
    localparam int ARM   = 3;
    localparam int STEP  = 5;
    localparam int NST   = 8;
    localparam int SS    = NST * STEP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_on = 1'b0, below_off = 1'b0, above_ovp = 1'b0, below_rel = 1'b0;
    logic reg_burst = 1'b0, ocp = 1'b0, mlow = 1'b0;
    logic gate_en, src_en, off_sel_high;
    logic [2:0] sink_code;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    supply_mode_sequencer #(.ARM_CYC(ARM), .STEP_CYC(STEP), .STEPS(NST)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_on(above_on), .vcc_below_off(below_off),
        .vcc_above_ovp(above_ovp), .vcc_below_rel(below_rel),
        .reg_below_burst(reg_burst), .ocp_fault(ocp), .mains_low(mlow),
        .gate_en(gate_en), .src_en(src_en), .sink_code(sink_code),
        .off_sel_high(off_sel_high)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse turn-on; returns at soft-start cycle 0.
    task automatic turn_on();
        above_on = 1'b1;
        @(negedge clk);
        above_on = 1'b0;
    endtask

    // Pulse a supply drop; returns in start-up.
    task automatic drop();
        below_off = 1'b1;
        @(negedge clk);
        below_off = 1'b0;
    endtask

    // Pulse the release flag.
    task automatic release_latch();
        below_rel = 1'b1;
        @(negedge clk);
        below_rel = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 gate after reset", gate_en, 0);
        chk("R1 src after reset", src_en, 0);
        chk("R1 code after reset", sink_code, 0);
        chk("R1 sel after reset", off_sel_high, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 waits in start-up", gate_en, 0);
        end

        // Full soft-start sweep (R2, R3, R4).
        turn_on();
        for (int k = 0; k < SS; k++) begin
            chk("R2 src window", src_en, (k < ARM) ? 1 : 0);
            chk("R3 step code", sink_code, NST - 1 - k / STEP);
            chk("R4 gate in soft-start", gate_en, 1);
            @(negedge clk);
        end
        chk("R4 normal code", sink_code, 0);
        chk("R4 normal src", src_en, 0);
        chk("R4 normal gate", gate_en, 1);

        // Burst entry and hold (R5, R6).
        reg_burst = 1'b1;
        @(negedge clk);
        reg_burst = 1'b0;
        chk("R5 burst gate", gate_en, 0);
        chk("R5 burst sel", off_sel_high, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R6 burst held", gate_en, 0);
        end

        // Exit to start-up keeps the select (R7).
        drop();
        chk("R7 exit gate", gate_en, 0);
        chk("R7 exit code", sink_code, 0);
        chk("R7 sel kept", off_sel_high, 1);
        repeat (3) @(negedge clk);
        chk("R7 still start-up", gate_en, 0);

        // Burst request held from turn-on: ignored until armed (R5, R7).
        reg_burst = 1'b1;
        turn_on();
        chk("R7 sel cleared", off_sel_high, 0);
        for (int k = 0; k <= ARM; k++) begin
            chk("R5 not armed yet", gate_en, 1);
            @(negedge clk);
        end
        chk("R5 armed burst gate", gate_en, 0);
        chk("R5 armed burst sel", off_sel_high, 1);
        reg_burst = 1'b0;
        drop();

        // Drop mid soft-start clears the timers (R7).
        turn_on();
        repeat (10) @(negedge clk);
        chk("R3 mid code", sink_code, NST - 1 - 10 / STEP);
        drop();
        chk("R7 drop code", sink_code, 0);
        chk("R7 drop src", src_en, 0);
        turn_on();
        chk("R7 restart code", sink_code, NST - 1);
        chk("R7 restart src", src_en, 1);
        repeat (SS) @(negedge clk);
        chk("R4 back to normal", gate_en, 1);

        // Fault latch (R8).
        above_ovp = 1'b1;
        @(negedge clk);
        above_ovp = 1'b0;
        chk("R8 ovp blocks", gate_en, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 latch held", gate_en, 0);
        end
        release_latch();
        chk("R8 released", gate_en, 1);
        ocp = 1'b1;
        below_rel = 1'b1;
        @(negedge clk);
        ocp = 1'b0;
        below_rel = 1'b0;
        chk("R8 set beats release", gate_en, 0);
        release_latch();
        chk("R8 ocp released", gate_en, 1);

        // Mains latch (R9).
        mlow = 1'b1;
        @(negedge clk);
        mlow = 1'b0;
        chk("R9 mains blocks", gate_en, 0);
        repeat (3) @(negedge clk);
        chk("R9 mains held", gate_en, 0);
        release_latch();
        chk("R9 mains released", gate_en, 1);

        // Latch across a restart (R10).
        above_ovp = 1'b1;
        @(negedge clk);
        above_ovp = 1'b0;
        drop();
        turn_on();
        chk("R10 src on", src_en, 1);
        chk("R10 gate blocked", gate_en, 0);
        release_latch();
        chk("R10 gate after release", gate_en, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule